// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small microcontroller core and decides when the core must leave its program flow to service an event. Each peripheral event arrives as a one-cycle pulse. The pulse is stored in a request flag whatever the flag's enable bit says. Flags that are both set and enabled compete in a fixed priority order. The winner is accepted only when the global enable is set and the core's return stack has room.

On acceptance the controller raises a one-cycle take strobe. The core uses this strobe to push its next-instruction address. In the same cycle the controller presents the winning source's vector as the new program counter, and it clears the global enable so that no second interrupt follows at once. Software can set the global enable again inside a service routine to allow nesting. The return-from-interrupt input also restores it.

Two sources, an EEPROM-write-done event and a low-voltage-detect event, do not have vectors of their own. They sit behind one multi-function vector, which has its own byte-wide flag and enable register. Any request flag that rises while the device sleeps or idles produces a wake pulse.

Top module: `irq_vec_ctrl`

## Requirements
- R1: An event pulse sets its request flag on the next clock edge, whatever its enable bit holds. A set flag whose enable is 0 never produces a take.
- R2: While the global enable `gie` is 0, `take` stays low and every pending flag stays latched.
- R3: When `gie` is 1, at least one enabled request is pending and `stack_full` is low at a clock edge, `take` is high for exactly the one cycle after that edge. During that cycle `vector` holds the winner's address, `VEC_BASE + slot*VEC_STEP`.
- R4: Acceptance clears `gie` at the same edge that raises `take`. Events arriving while `gie` is 0 are still latched.
- R5: A `gie_set` or `reti` pulse sets `gie` at the next edge, which allows nesting inside a service routine. A `gie_clr` pulse clears it. Acceptance takes precedence over `gie_clr`, and `gie_clr` takes precedence over `gie_set` and `reti`.
- R6: While `stack_full` is 1, no request is accepted. The request is accepted at the first edge at which `stack_full` is low.
- R7: Priority is fixed and the lowest slot wins. Slots below `MF_SLOT` carry direct sources 0 upward, slot `MF_SLOT` carries the multi-function group, and the slots above it carry the remaining direct sources. With the defaults the vectors are: direct 0 = 4, direct 1 = 8, group = 12, direct 2 = 16, direct 3 = 20.
- R8: The multi-function register reads as bit 5 = EEPROM-done flag, bit 4 = low-voltage flag, bit 1 = EEPROM-done enable and bit 0 = low-voltage enable. Bits 7..6 and 3..2 read as 0. The register resets to 0. A write loads bits 5, 4, 1 and 0.
- R9: The group requests arbitration when any group flag is set together with its enable. Taking the group vector leaves the group flags unchanged, so only software writes clear them.
- R10: Taking a direct source's vector clears that source's flag. If that source's event arrives in the same cycle, the flag stays set.
- R11: `wake` is high in the cycle after an edge at which `sleep_mode` was 1 and some flag (direct or group) went from 0 to 1. A flag that was already set causes no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_dir | input | N_DIRECT | One-cycle event pulses, direct-vector sources |
| ee_done_evt | input | 1 | EEPROM write-done event pulse (group source) |
| lvd_evt | input | 1 | Low-voltage-detect event pulse (group source) |
| en_we | input | 1 | Write strobe for the direct enable bits |
| en_wdata | input | N_DIRECT | New direct enable bits |
| mf_we | input | 1 | Write strobe for the multi-function register |
| mf_wdata | input | 8 | Write data, multi-function register |
| gie_set | input | 1 | Software sets the global enable |
| gie_clr | input | 1 | Software clears the global enable |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| stack_full | input | 1 | Core return stack is full |
| sleep_mode | input | 1 | Device is in sleep or idle mode |
| take | output | 1 | Take-interrupt strobe: push the return address and load the vector |
| vector | output | PC_W | Vector address of the accepted source |
| gie | output | 1 | Global enable state |
| flag_dir | output | N_DIRECT | Direct request flags |
| mf_rdata | output | 8 | Multi-function register readback |
| wake | output | 1 | Wake-up pulse |

## Verification
On every cycle the embedded properties check the following. No take occurs while the global enable is off or the stack is full. A take is a single-cycle pulse and always comes with a cleared global enable. An event always leaves its flag set. A hardware clear without a coincident event empties the flag. The grant is never more than one-hot. A wake pulse appears only after a cycle spent in sleep mode. The bench scenarios are needed for the rest: the choice of vector among concurrent requests, the placement of the group slot, the register bit layout, the wake rule for flags that were already set, and the event-over-clear collision. A bench-side cycle model compares these against the outputs during directed and random traffic.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Vector address of an arbitration slot.
  function automatic int slot_vector(int slot, int base, int step);
    return base + slot * step;
  endfunction

  // Slot that a direct source occupies, given where the group slot sits.
  function automatic int direct_to_slot(int dsrc, int mf_slot);
    return (dsrc < mf_slot) ? dsrc : dsrc + 1;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag,
  output logic [N-1:0] rise
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | evt;
  end

  // a flag about to go 0 -> 1
  assign rise = evt & ~flag_q;
  assign flag = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R1
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag_q[i]);
    // R10
    clr_empties_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !evt[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/irq_mf_group.sv
module irq_mf_group (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ee_evt,
  input  logic       lvd_evt,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       req,
  output logic       rise
);
  // index 1 = EEPROM done, index 0 = low voltage
  logic [1:0] flg_q, ena_q, flg_nx, evt2;
  logic       unused_wbits;

  assign evt2   = {ee_evt, lvd_evt};
  assign flg_nx = (we ? wdata[5:4] : flg_q) | evt2;
  assign unused_wbits = ^{wdata[7:6], wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      ena_q <= '0;
    end else begin
      flg_q <= flg_nx;
      if (we) ena_q <= wdata[1:0];
    end
  end

  assign rdata = {2'b00, flg_q, 2'b00, ena_q};
  assign req   = |(flg_q & ena_q);
  assign rise  = |(flg_nx & ~flg_q);

  // R1
  grp_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_evt || lvd_evt) |=> (flg_q & $past(evt2)) == $past(evt2));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int s = N - 1; s >= 0; s--) begin
      if (req[s]) grant = N'(1) << s;
    end
  end
  assign any = |req;

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int N_DIRECT = 4,
  parameter int MF_SLOT  = 2,
  parameter int PC_W     = 12,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_DIRECT-1:0] evt_dir,
  input  logic                ee_done_evt,
  input  logic                lvd_evt,
  input  logic                en_we,
  input  logic [N_DIRECT-1:0] en_wdata,
  input  logic                mf_we,
  input  logic [7:0]          mf_wdata,
  input  logic                gie_set,
  input  logic                gie_clr,
  input  logic                reti,
  input  logic                stack_full,
  input  logic                sleep_mode,
  output logic                take,
  output logic [PC_W-1:0]     vector,
  output logic                gie,
  output logic [N_DIRECT-1:0] flag_dir,
  output logic [7:0]          mf_rdata,
  output logic                wake
);
  localparam int N_SLOT = N_DIRECT + 1;

  logic [N_DIRECT-1:0] en_q, pend_dir, clr_dir, dir_rise;
  logic [N_SLOT-1:0]   slot_req, grant;
  logic                mf_req, mf_rise, any_req, accept;
  logic                gie_q, take_q, wake_q;
  logic [PC_W-1:0]     vec_q, sel_vec;

  irq_flag_bank #(.N(N_DIRECT)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_dir), .clr(clr_dir),
    .flag(flag_dir), .rise(dir_rise)
  );

  irq_mf_group u_group (
    .clk(clk), .rst_n(rst_n), .ee_evt(ee_done_evt), .lvd_evt(lvd_evt),
    .we(mf_we), .wdata(mf_wdata), .rdata(mf_rdata),
    .req(mf_req), .rise(mf_rise)
  );

  assign pend_dir = flag_dir & en_q;

  // slot mapping: group at MF_SLOT, direct sources fill the rest in order
  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    if (s == MF_SLOT) begin : g_mf
      assign slot_req[s] = mf_req;
    end else if (s < MF_SLOT) begin : g_lo
      assign slot_req[s] = pend_dir[s];
    end else begin : g_hi
      assign slot_req[s] = pend_dir[s-1];
    end
  end

  irq_prio_arb #(.N(N_SLOT)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(slot_req), .grant(grant), .any(any_req)
  );

  assign accept = gie_q & any_req & ~stack_full;

  for (genvar d = 0; d < N_DIRECT; d++) begin : g_clr
    assign clr_dir[d] = accept & grant[irq_pkg::direct_to_slot(d, MF_SLOT)];
  end

  always_comb begin
    sel_vec = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      if (grant[s]) sel_vec = PC_W'(irq_pkg::slot_vector(s, VEC_BASE, VEC_STEP));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      gie_q  <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_wdata;
      if (accept)              gie_q <= 1'b0;
      else if (gie_clr)        gie_q <= 1'b0;
      else if (gie_set | reti) gie_q <= 1'b1;
      take_q <= accept;
      if (accept) vec_q <= sel_vec;
      wake_q <= sleep_mode & ((|dir_rise) | mf_rise);
    end
  end

  assign take   = take_q;
  assign vector = vec_q;
  assign gie    = gie_q;
  assign wake   = wake_q;

  // R2
  no_take_gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !take_q);
  // R6
  full_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |=> !take_q);
  // R3
  take_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q);
  // R4
  gie_drop_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> !gie_q);
  // R11
  wake_only_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(sleep_mode));
endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] evt_dir = '0, en_wdata = '0;
  logic ee_done_evt = 0, lvd_evt = 0, en_we = 0, mf_we = 0;
  logic [7:0] mf_wdata = '0;
  logic gie_set = 0, gie_clr = 0, reti = 0, stack_full = 0, sleep_mode = 0;
  logic take, gie, wake;
  logic [11:0] vector;
  logic [3:0] flag_dir;
  logic [7:0] mf_rdata;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_dir(evt_dir), .ee_done_evt(ee_done_evt),
    .lvd_evt(lvd_evt), .en_we(en_we), .en_wdata(en_wdata), .mf_we(mf_we),
    .mf_wdata(mf_wdata), .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
    .stack_full(stack_full), .sleep_mode(sleep_mode), .take(take),
    .vector(vector), .gie(gie), .flag_dir(flag_dir), .mf_rdata(mf_rdata),
    .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [3:0] m_fd = '0, m_en = '0;
  logic [1:0] m_fg = '0, m_ge = '0;   // [1]=EEPROM done, [0]=low voltage
  logic m_gie = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int b_vec(int slot);
    return 4 * (slot + 1);
  endfunction

  // requests in slot order: d0, d1, group, d2, d3
  function automatic logic [4:0] b_slots(logic [3:0] fd, logic [3:0] en,
                                         logic [1:0] fg, logic [1:0] ge);
    logic [3:0] p;
    p = fd & en;
    return {p[3], p[2], |(fg & ge), p[1], p[0]};
  endfunction

  function automatic int b_winner(logic [4:0] r);
    for (int s = 0; s < 5; s++) if (r[s]) return s;
    return -1;
  endfunction

  // one clock: model from current inputs, advance, compare, clear pulses
  task automatic cyc();
    logic [4:0] r;
    logic [3:0] clr, fd_n, en_n;
    logic [1:0] fg_n, ge_n;
    logic acc, gie_n, wake_n;
    int w;
    r = b_slots(m_fd, m_en, m_fg, m_ge);
    acc = m_gie && (r != 0) && !stack_full;
    w = b_winner(r);
    clr = '0;
    if (acc && w != 2) clr[(w < 2) ? w : w - 1] = 1'b1;
    fd_n = (m_fd & ~clr) | evt_dir;
    fg_n = (mf_we ? mf_wdata[5:4] : m_fg) | {ee_done_evt, lvd_evt};
    ge_n = mf_we ? mf_wdata[1:0] : m_ge;
    en_n = en_we ? en_wdata : m_en;
    gie_n = acc ? 1'b0 : gie_clr ? 1'b0 : (gie_set || reti) ? 1'b1 : m_gie;
    wake_n = sleep_mode && (((fd_n & ~m_fd) != 0) || ((fg_n & ~m_fg) != 0));
    @(posedge clk); #1;
    m_fd = fd_n; m_en = en_n; m_fg = fg_n; m_ge = ge_n; m_gie = gie_n;
    chk(take === acc, "R3 take", take, acc);
    if (acc) chk(vector === 12'(b_vec(w)), "R7 vector", vector, b_vec(w));
    chk(gie === gie_n, "R4/R5 gie", gie, gie_n);
    chk(flag_dir === fd_n, "R1/R10 flags", flag_dir, fd_n);
    chk(mf_rdata === {2'b0, fg_n, 2'b0, ge_n}, "R8/R9 mf reg", mf_rdata,
        {2'b0, fg_n, 2'b0, ge_n});
    chk(wake === wake_n, "R11 wake", wake, wake_n);
    evt_dir = '0; ee_done_evt = 0; lvd_evt = 0; en_we = 0; mf_we = 0;
    gie_set = 0; gie_clr = 0; reti = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R8 reset state
    chk(take === 0 && gie === 0, "R8 reset take/gie", {take, gie}, 0);
    chk(mf_rdata === 8'h00 && flag_dir === 4'h0, "R8 reset regs", mf_rdata, 0);

    // R1: flag latched with enable off
    evt_dir = 4'b0010; cyc();
    chk(flag_dir === 4'b0010, "R1 flag with en off", flag_dir, 4'b0010);
    // R2: enables on, gie off: no take, flags stay
    en_we = 1; en_wdata = 4'hF; evt_dir = 4'b1000; cyc();
    cyc(); cyc();
    chk(take === 0 && flag_dir === 4'b1010, "R2 held pending", flag_dir, 4'b1010);
    gie_set = 1; cyc();
    // R3/R7/R10/R4: direct1 beats direct3
    cyc();
    chk(take === 1 && vector === 12'd8, "R7 direct1 wins", vector, 8);
    chk(gie === 0 && flag_dir === 4'b1000, "R10 flag cleared", flag_dir, 4'b1000);
    cyc();
    chk(take === 0, "R3 single pulse", take, 0);
    // R5: reti restores gie
    reti = 1; cyc();
    chk(gie === 1, "R5 reti sets gie", gie, 1);
    cyc();
    chk(take === 1 && vector === 12'd20, "R7 direct3 vector", vector, 20);
    // R6: stack full holds acceptance
    evt_dir = 4'b0001; stack_full = 1; cyc();
    gie_set = 1; cyc(); cyc(); cyc();
    chk(take === 0 && flag_dir[0] === 1, "R6 blocked while full", take, 0);
    stack_full = 0; cyc();
    chk(take === 1 && vector === 12'd4, "R6 taken after release", vector, 4);
    // R9: group beats direct2, group flag not cleared
    mf_we = 1; mf_wdata = 8'h01; lvd_evt = 1; evt_dir = 4'b0100; cyc();
    chk(mf_rdata === 8'h11, "R8 mf layout", mf_rdata, 8'h11);
    gie_set = 1; cyc(); cyc();
    chk(take === 1 && vector === 12'd12, "R9 group vector", vector, 12);
    chk(mf_rdata === 8'h11 && flag_dir === 4'b0100, "R9 group flag kept", mf_rdata, 8'h11);
    mf_we = 1; mf_wdata = 8'h00; reti = 1; cyc(); cyc();
    chk(take === 1 && vector === 12'd16, "R7 direct2 after group", vector, 16);
    // R8: unused bits read 0
    mf_we = 1; mf_wdata = 8'hFF; cyc();
    chk(mf_rdata === 8'h33, "R8 unused bits zero", mf_rdata, 8'h33);
    mf_we = 1; mf_wdata = 8'h00; cyc();
    // R11: wake on rise only
    sleep_mode = 1; evt_dir = 4'b0001; cyc();
    chk(wake === 1, "R11 wake on rise", wake, 1);
    cyc();
    evt_dir = 4'b0001; cyc();
    chk(wake === 0, "R11 no wake when already set", wake, 0);
    sleep_mode = 0;
    // R10: event coincident with clear keeps flag
    gie_set = 1; cyc();
    evt_dir = 4'b0001; cyc();
    chk(take === 1 && flag_dir[0] === 1, "R10 event wins over clear", flag_dir, 1);
    // R5: gie_clr beats gie_set
    gie_set = 1; gie_clr = 1; cyc();
    chk(gie === 0, "R5 clr over set", gie, 0);

    // constrained random traffic
    for (int k = 0; k < 3000; k++) begin
      for (int b = 0; b < 4; b++) evt_dir[b] = ($urandom % 8) == 0;
      ee_done_evt = ($urandom % 10) == 0;
      lvd_evt     = ($urandom % 10) == 0;
      en_we = ($urandom % 16) == 0; en_wdata = 4'($urandom);
      mf_we = ($urandom % 16) == 0; mf_wdata = 8'($urandom);
      gie_set = ($urandom % 6) == 0;
      gie_clr = ($urandom % 20) == 0;
      reti    = ($urandom % 8) == 0;
      stack_full = ($urandom % 4) == 0;
      sleep_mode = ($urandom % 3) == 0;
      cyc();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule